// File: doc/BRIEF.md
# Quad Strobed Display-Line Driver

This block drives four single-bit display lines, such as a decimal point, a colon or a sign indicator, next to a seven-segment decoder. Each line stores one select bit. That bit is captured from its own data input on a clock edge while the line's own strobe is high, and it is held while the strobe is low.

All four lines share one phase input. Each line's drive level is its stored select bit combined with that phase, so the lines use the same polarity convention as the segment decoder. When the phase input carries a square wave, a selected line swings in antiphase to it and an unselected line swings in phase with it. That is the drive a liquid-crystal display needs.

Any line can also serve as the common-electrode drive: hold its data low and its strobe high, and the line then copies the phase input. Supply-level translation is left to the pad ring.

Top module: `quad_line_driver`

## Requirements
- R1: While rst_n is low, every stored select bit is 0 (unselected), so each output equals df_in. The reset is asynchronous.
- R2: On a rising clk edge with rst_n high and strobe[i] = 1, line i stores d[i]. The value 1 means selected.
- R3: On a rising clk edge with strobe[i] = 0, line i keeps its stored bit whatever d[i] does.
- R4: A strobe affects only its own line. Changing d on lines whose strobe is low leaves their outputs unchanged.
- R5: With df_in = 0, a selected line drives 1 and an unselected line drives 0.
- R6: With df_in = 1, a selected line drives 0 and an unselected line drives 1.
- R7: A change of df_in reaches every output in the same cycle, without waiting for a clock edge. With the stored bits steady, every output inverts whenever df_in toggles.
- R8: A line whose d is 0 and whose strobe is 1 at a clock edge copies df_in from that edge onward, which makes it a common-electrode drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that captures the select bits |
| rst_n | input | 1 | Active-low asynchronous reset; clears all select bits |
| d | input | 4 | Per-line select data (1 = selected) |
| strobe | input | 4 | Per-line load enable (1 = capture on the edge, 0 = hold) |
| df_in | input | 1 | Shared display phase |
| out | output | 4 | Per-line drive level |

## Verification
A captured select bit shows on its output right after the rising edge that loads it, one register deep. A change on df_in or a reset shows on the outputs at once, through logic only.

The bench drives new inputs just after each falling edge. It compares every output with its model 1 ns later, which covers the purely combinational phase and reset paths. It compares again 1 ns after the next rising edge, once the model has applied the strobed loads that edge caused.

// File: rtl/qld_pkg.sv
package qld_pkg;

  // Drive level of one line: a selected line is the inverse of the phase.
  function automatic logic line_level(input logic sel, input logic phase);
    return sel ^ phase;
  endfunction

  // Next stored select bit for one line.
  function automatic logic next_sel(input logic cur, input logic load, input logic din);
    return load ? din : cur;
  endfunction

endpackage

// File: rtl/qld_line_latch.sv
module qld_line_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic din,
  output logic q
);
  import qld_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= next_sel(q, load, din);
  end

endmodule

// File: rtl/qld_phase_mod.sv
module qld_phase_mod #(
  parameter int LINES = 4
) (
  input  logic [LINES-1:0] sel,
  input  logic             phase,
  output logic [LINES-1:0] level
);
  import qld_pkg::*;

  for (genvar g = 0; g < LINES; g++) begin : g_mod
    assign level[g] = line_level(sel[g], phase);
  end

endmodule

// File: rtl/quad_line_driver.sv
module quad_line_driver #(
  parameter int LINES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] d,
  input  logic [LINES-1:0] strobe,
  input  logic             df_in,
  output logic [LINES-1:0] out
);

  // Stored select bits, brought out by name for the checker.
  logic [LINES-1:0] lat_q;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    qld_line_latch u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (strobe[g]),
      .din   (d[g]),
      .q     (lat_q[g])
    );
  end

  qld_phase_mod #(.LINES(LINES)) u_mod (
    .sel   (lat_q),
    .phase (df_in),
    .level (out)
  );

endmodule

// File: rtl/quad_line_driver_chk.sv
module quad_line_driver_chk #(
  parameter int LINES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LINES-1:0] d,
  input logic [LINES-1:0] strobe,
  input logic             df_in,
  input logic [LINES-1:0] out,
  input logic [LINES-1:0] lat_q
);

  // R2: strobed lines hold the data sampled at the previous edge
  assert_strobe_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobe) |=> (((lat_q ^ $past(d)) & $past(strobe)) == '0));

  // R3 / R4: lines without strobe keep their bit
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe != '1) |=> (((lat_q ^ $past(lat_q)) & ~$past(strobe)) == '0));

  // R7: with select bits steady, a phase toggle inverts every output
  assert_phase_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((df_in != $past(df_in)) && $stable(lat_q)) |-> (out == ~$past(out)));

  // R8: a line loaded with 0 tracks the phase input
  assert_common_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(strobe & ~d)) |=> (((out ^ {LINES{df_in}}) & $past(strobe & ~d)) == '0));

endmodule

bind quad_line_driver quad_line_driver_chk #(.LINES(LINES)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .d      (d),
  .strobe (strobe),
  .df_in  (df_in),
  .out    (out),
  .lat_q  (lat_q)
);

// File: tb/tb_quad_line_driver.sv
`timescale 1ns/1ps
module tb_quad_line_driver;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] d = '0;
  logic [3:0] strobe = '0;
  logic       df_in = 1'b0;
  logic [3:0] out;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit ref_q [4];

  quad_line_driver dut (
    .clk(clk), .rst_n(rst_n), .d(d), .strobe(strobe), .df_in(df_in), .out(out)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 50000) begin
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<50000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [3:0] expect_out();
    logic [3:0] e;
    for (int i = 0; i < 4; i++) begin
      if (ref_q[i]) e[i] = (df_in == 1'b0);
      else          e[i] = (df_in == 1'b1);
    end
    return e;
  endfunction

  task automatic check(input string tag);
    logic [3:0] e;
    e = expect_out();
    total++;
    if (out !== e) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, out, e, $time);
    end
  endtask

  task automatic cyc(input logic [3:0] dv, input logic [3:0] sv, input logic dfv,
                     input string tag);
    @(negedge clk);
    d = dv; strobe = sv; df_in = dfv;
    #1 check(tag);
    @(posedge clk);
    for (int i = 0; i < 4; i++) if (sv[i]) ref_q[i] = dv[i];
    #1 check(tag);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) ref_q[i] = 1'b0;
    // R1: reset state
    repeat (2) @(negedge clk);
    #1 check("R1");
    df_in = 1'b1;
    #1 check("R1");
    df_in = 1'b0;
    d = 4'b1111; strobe = 4'b1111;
    @(posedge clk); #1 check("R1");
    @(negedge clk);
    rst_n = 1'b1;
    strobe = '0;

    // R2 + R5: load pattern, phase low
    cyc(4'b1010, 4'b1111, 1'b0, "R2");
    cyc(4'b1010, 4'b0000, 1'b0, "R5");
    // R3: strobe low, data changes ignored
    cyc(4'b0101, 4'b0000, 1'b0, "R3");
    cyc(4'b1111, 4'b0000, 1'b0, "R3");
    // R6: phase high
    cyc(4'b0000, 4'b0000, 1'b1, "R6");
    // R4: single strobe
    cyc(4'b1111, 4'b0001, 1'b1, "R4");
    cyc(4'b0000, 4'b0100, 1'b0, "R4");
    // R7: phase toggles mid-cycle
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      strobe = '0;
      df_in = ~df_in;
      #1 check("R7");
      #1 df_in = ~df_in;
      #0.2 check("R7");
    end
    // R8: line 3 as common electrode, others selected
    cyc(4'b0111, 4'b1111, 1'b0, "R8");
    for (int k = 0; k < 8; k++) begin
      cyc(4'b0111, 4'b1000, k[0], "R8");
      total++;
      if (out[3] !== df_in) begin
        bad++;
        $display("FAIL R8: actual=%b expected=%b", out[3], df_in);
      end
    end
    // R2/R3 mixed patterns
    for (int k = 0; k < 200; k++)
      cyc(4'($urandom), 4'($urandom), 1'($urandom), "R2");
    // R1: reset mid-run clears asynchronously
    cyc(4'b1111, 4'b1111, 1'b0, "R2");
    @(negedge clk);
    strobe = '0;
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) ref_q[i] = 1'b0;
    #1 check("R1");
    @(negedge clk);
    rst_n = 1'b1;
    cyc(4'b0011, 4'b0011, 1'b1, "R2");
    cyc(4'b1100, 4'b0000, 1'b1, "R3");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule